// File: doc/BRIEF.md
# USB Full/Low-Speed Receive Bit Destuffer

This block sits behind the NRZI decoder of a full- or low-speed USB receiver. It takes one decoded bit per `bit_vld` strobe, framed by a start-of-packet strobe and an end-of-packet strobe. It removes the zero that the transmitter inserts after every run of six ones. It packs the remaining data bits into bytes, least significant bit first. It also watches for runs of ones that are too long.

A run of seven ones inside a packet is a stuffing error. From that point the block drops every bit up to the end of the packet and flags the packet as bad. The block tolerates a run of six ones that reaches the end of the packet with no stuffed zero after it. This happens when hub skew stretches the last bit (dribble). Any bits left over past the last whole byte, including such a dribble bit, are thrown away at end of packet. Whether a packet ends cleanly or in error, the block goes back to idle and accepts the next packet with no reset.

Top module: `usb_unstuffer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `byte_vld`, `pkt_end` and `pkt_err` are low.
- R2: A zero that follows six consecutive ones is removed and never appears in an output byte.
- R3: A one that follows six consecutive ones is a stuffing error. `pkt_err` is then high, together with the `pkt_end` pulse, for that packet.
- R4: Six consecutive ones followed directly by end of packet are not an error.
- R5: After a stuffing error, no bytes are delivered for the rest of that packet, whatever bits arrive.
- R6: Data bits are packed least significant bit first. Each eighth data bit produces one `byte_vld` pulse, with the byte on `byte_out`, in the cycle after that bit is accepted.
- R7: Data bits past the last whole byte at end of packet (partial or dribble bits) are discarded and never delivered.
- R8: After a packet that ended in error, the next packet is received normally with no reset.
- R9: Bits arriving while idle are ignored. A start-of-packet strobe clears the ones run and any partly assembled byte, even in the middle of a packet.
- R10: Each end-of-packet strobe inside a packet gives exactly one single-cycle `pkt_end` pulse. An end-of-packet strobe while idle gives none.
- R11: The ones run restarts after a removed stuffed zero, so repeated runs of six ones, each followed by a stuffed zero, are not errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Start-of-packet strobe |
| eop | input | 1 | End-of-packet strobe; a bit strobed in the same cycle is ignored |
| bit_vld | input | 1 | Decoded bit strobe |
| bit_in | input | 1 | Decoded (post-NRZI) bit value |
| byte_vld | output | 1 | One-cycle pulse: a data byte is on `byte_out` |
| byte_out | output | BYTE_W | Assembled byte, first received bit in bit 0 |
| pkt_end | output | 1 | One-cycle pulse at the end of each packet |
| pkt_err | output | 1 | High with `pkt_end` when the packet had a stuffing error |

## Verification
The hardest cases to reach from the ports involve the ones run at packet edges. One is a run of six that meets end of packet, where a single extra one would turn a dribble into an error. The other is a run left over when a new start-of-packet strobe interrupts a packet. The stimulus builds the line bits by hand in these places. It sends a byte ending in five ones plus one extra one before end of packet. It also sends five ones, restarts the packet, and then sends a byte whose first two bits are ones. In the second case seven ones would be seen if the run were not cleared. The bench works out the expected bytes and error flag from the same line bits, using the stuffing rules alone.

// File: rtl/usb_unstuff_pkg.sv
package usb_unstuff_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_t;

  typedef enum logic [1:0] {
    BIT_NONE  = 2'd0,
    BIT_DATA  = 2'd1,
    BIT_STUFF = 2'd2,
    BIT_ERR   = 2'd3
  } bit_kind_t;

endpackage

// File: rtl/usb_unstuff_run.sv
module usb_unstuff_run
  import usb_unstuff_pkg::*;
#(
  parameter int RUN_LIMIT = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      take,
  input  logic      bit_in,
  output bit_kind_t kind
);
  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic [CW-1:0] ones_q;

  // Classify the bit being accepted from the length of the current run
  always_comb begin
    kind = BIT_NONE;
    if (take) begin
      if (ones_q == LIM) kind = bit_in ? BIT_ERR : BIT_STUFF;
      else               kind = BIT_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= '0;
    end else if (take) begin
      if (kind == BIT_DATA && bit_in) ones_q <= ones_q + 1'b1;
      else                            ones_q <= '0;
    end
  end

endmodule

// File: rtl/usb_unstuff_pack.sv
module usb_unstuff_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              din,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sr_nx;

  assign sr_nx = {din, sr_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (flush) begin
        cnt_q <= '0;
      end else if (push) begin
        sr_q <= sr_nx;
        if (cnt_q == LAST) begin
          cnt_q    <= '0;
          byte_out <= sr_nx;
          byte_vld <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/usb_unstuff_fsm.sv
module usb_unstuff_fsm
  import usb_unstuff_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sop,
  input  logic      eop,
  input  logic      bit_vld,
  input  logic      err_hit,
  output rx_state_t state,
  output logic      take,
  output logic      restart,
  output logic      pkt_end,
  output logic      pkt_err
);

  assign restart = sop | eop;
  assign take    = (state == ST_RECV) & bit_vld & ~sop & ~eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pkt_end <= 1'b0;
      pkt_err <= 1'b0;
    end else begin
      pkt_end <= 1'b0;
      pkt_err <= 1'b0;
      if (eop && state != ST_IDLE) begin
        state   <= ST_IDLE;
        pkt_end <= 1'b1;
        pkt_err <= (state == ST_DROP);
      end else if (sop) begin
        state <= ST_RECV;
      end else if (err_hit) begin
        state <= ST_DROP;
      end
    end
  end

endmodule

// File: rtl/usb_unstuffer.sv
module usb_unstuffer
  import usb_unstuff_pkg::*;
#(
  parameter int RUN_LIMIT = 6,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop,
  input  logic              eop,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              pkt_end,
  output logic              pkt_err
);

  rx_state_t state;
  bit_kind_t kind;
  logic      take;
  logic      restart;
  logic      err_hit;
  logic      push;
  logic      in_drop;

  assign err_hit = (kind == BIT_ERR);
  assign push    = (kind == BIT_DATA);
  assign in_drop = (state == ST_DROP);

  usb_unstuff_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .sop     (sop),
    .eop     (eop),
    .bit_vld (bit_vld),
    .err_hit (err_hit),
    .state   (state),
    .take    (take),
    .restart (restart),
    .pkt_end (pkt_end),
    .pkt_err (pkt_err)
  );

  usb_unstuff_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .take   (take),
    .bit_in (bit_in),
    .kind   (kind)
  );

  usb_unstuff_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .flush    (restart),
    .push     (push),
    .din      (bit_in),
    .byte_vld (byte_vld),
    .byte_out (byte_out)
  );

endmodule

// File: rtl/usb_unstuff_chk.sv
module usb_unstuff_chk (
  input logic clk,
  input logic rst,
  input logic byte_vld,
  input logic pkt_end,
  input logic pkt_err,
  input logic in_drop
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!byte_vld && !pkt_end && !pkt_err));

  // R3
  err_with_end_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_err |-> pkt_end);

  // R5
  drop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    in_drop |-> !byte_vld);

  // R10
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end);

  // R7
  byte_end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld && pkt_end));

endmodule

bind usb_unstuffer usb_unstuff_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .byte_vld (byte_vld),
  .pkt_end  (pkt_end),
  .pkt_err  (pkt_err),
  .in_drop  (in_drop)
);

// File: tb/test_usb_unstuffer.sv
`timescale 1ns/1ps
module test_usb_unstuffer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sop = 1'b0;
  logic       eop = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic       byte_vld;
  logic [7:0] byte_out;
  logic       pkt_end;
  logic       pkt_err;

  int checks = 0;
  int bad = 0;
  int ends_seen = 0;
  int ends_exp = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [7:0] exp_b[$];
  logic       exp_e[$];
  logic       line_q[$];
  int         stuff_run = 0;

  always #2 clk = ~clk;

  usb_unstuffer i_usb_unstuffer (
    .clk(clk), .rst(rst), .sop(sop), .eop(eop), .bit_vld(bit_vld),
    .bit_in(bit_in), .byte_vld(byte_vld), .byte_out(byte_out),
    .pkt_end(pkt_end), .pkt_err(pkt_err)
  );

  // Monitor: compare outputs against the scoreboard queues
  always @(negedge clk) begin
    if (!rst && byte_vld) begin
      checks++;
      if (exp_b.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected byte: got %h exp none", cur_req, byte_out);
      end else begin
        logic [7:0] e;
        e = exp_b.pop_front();
        if (byte_out !== e) begin
          bad++;
          $display("FAIL %s byte: got %h exp %h", cur_req, byte_out, e);
        end
      end
    end
    if (!rst && pkt_end) begin
      ends_seen++;
      checks++;
      if (exp_e.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected pkt_end: got 1 exp 0", cur_req);
      end else begin
        logic e;
        e = exp_e.pop_front();
        if (pkt_err !== e) begin
          bad++;
          $display("FAIL %s pkt_err: got %b exp %b", cur_req, pkt_err, e);
        end
      end
    end
  end

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      line_q.push_back(b[i]);
      if (b[i]) begin
        stuff_run++;
        if (stuff_run == 6) begin
          line_q.push_back(1'b0);
          stuff_run = 0;
        end
      end else begin
        stuff_run = 0;
      end
    end
  endtask

  task automatic add_raw(input logic b, input int n);
    for (int i = 0; i < n; i++) line_q.push_back(b);
  endtask

  // Expected results from the stuffing rules
  task automatic predict();
    int run = 0;
    int n = 0;
    logic [7:0] acc = '0;
    logic err = 1'b0;
    foreach (line_q[i]) begin
      if (!err) begin
        if (run == 6) begin
          if (line_q[i]) err = 1'b1;
          else run = 0;
        end else begin
          if (line_q[i]) run++;
          else run = 0;
          acc[n] = line_q[i];
          n++;
          if (n == 8) begin
            exp_b.push_back(acc);
            n = 0;
          end
        end
      end
    end
    exp_e.push_back(err);
    ends_exp++;
  endtask

  task automatic drive_bits(input int gap);
    foreach (line_q[i]) begin
      bit_vld = 1'b1;
      bit_in  = line_q[i];
      @(posedge clk); #1;
      bit_vld = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic send_pkt(input string tag, input int gap);
    predict();
    cur_req = tag;
    sop = 1'b1;
    @(posedge clk); #1;
    sop = 1'b0;
    drive_bits(gap);
    eop = 1'b1;
    @(posedge clk); #1;
    eop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
    end
    line_q.delete();
    stuff_run = 0;
  endtask

  task automatic check_drained(input string tag);
    checks++;
    if (exp_b.size() != 0 || exp_e.size() != 0) begin
      bad++;
      $display("FAIL %s leftover: got bytes=%0d ends=%0d exp 0", tag, exp_b.size(), exp_e.size());
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs right after reset
    checks++;
    if (byte_vld !== 1'b0 || pkt_end !== 1'b0 || pkt_err !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs: got %b%b%b exp 000", byte_vld, pkt_end, pkt_err);
    end
    @(posedge clk); #1;

    // R6: plain bytes, LSB first, back-to-back bits
    add_byte(8'hA5); add_byte(8'h3C); add_byte(8'h81);
    send_pkt("R6", 0);
    check_drained("R6");

    // R2 R11: runs of ones that need stuffed zeros, bits with gaps
    add_byte(8'hFF); add_byte(8'hFF); add_byte(8'h7E);
    send_pkt("R2_R11", 2);
    check_drained("R2_R11");

    // R3 R5: seven ones, then a full byte of trailing bits that must be dropped
    add_byte(8'h12);
    add_raw(1'b0, 1);
    add_raw(1'b1, 7);
    add_byte(8'h55); add_byte(8'h0F);
    send_pkt("R3_R5", 1);
    check_drained("R3_R5");

    // R8: clean packet straight after an error packet
    add_byte(8'hC3); add_byte(8'h99);
    send_pkt("R8", 0);
    check_drained("R8");

    // R4 R7: byte ending in five ones plus one dribble one before EOP
    add_byte(8'hF8);
    add_raw(1'b1, 1);
    send_pkt("R4_R7", 0);
    check_drained("R4_R7");

    // R4: byte ending in six ones (stuffed zero) plus dribble one
    add_byte(8'hFC);
    add_raw(1'b1, 1);
    send_pkt("R4", 3);
    check_drained("R4");

    // R7: three partial bits after a whole byte
    add_byte(8'h6D);
    add_raw(1'b0, 1); add_raw(1'b1, 2);
    send_pkt("R7", 0);
    check_drained("R7");

    // R9 R10: bits and EOP while idle give nothing
    cur_req = "R9_R10";
    add_raw(1'b1, 9); add_raw(1'b0, 8);
    drive_bits(0);
    line_q.delete();
    eop = 1'b1;
    @(posedge clk); #1;
    eop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
    end
    check_drained("R9_R10");

    // R9: SOP mid-packet clears a run of five ones and the partial byte
    cur_req = "R9";
    sop = 1'b1;
    @(posedge clk); #1;
    sop = 1'b0;
    add_raw(1'b1, 5);
    drive_bits(0);
    line_q.delete();
    add_byte(8'h03); add_byte(8'hE7);
    send_pkt("R9", 0);
    check_drained("R9");

    // R10: one pkt_end per packet in total
    checks++;
    if (ends_seen != ends_exp) begin
      bad++;
      $display("FAIL R10 pkt_end count: got %0d exp %0d", ends_seen, ends_exp);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule